// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It holds a program counter, a word-addressed instruction store, a 32-entry register file with two combinational read ports and one clocked write port, an ALU, and a word-addressed data store. Decoding happens in two levels. A main decoder looks at the opcode and produces the datapath selects plus a 2-bit ALU class. A second decoder combines that class with the function field to choose the ALU operation.

The supported instructions are the register-register group (add, sub, and, or, nor, slt), word load, word store, branch-if-equal, jump, and jump-and-link. The program counter, the register file and the data store change only at the rising clock edge. Everything else settles combinationally within the cycle. The instruction store is filled by the environment before reset is released.

Observation ports carry the current PC and, for the current cycle, the register write and the data-store write that will take effect at the next edge. These ports let the surrounding environment follow retirement one cycle at a time.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 and no register or data-store write is reported. The first instruction executed after release is the one at byte address 0.
- R2: An instruction that is not beq, j or jal sets the next PC to the current PC + 4. The PC is always a multiple of 4.
- R3: Register-register instructions have opcode 000000 and write their result to rd, instr[15:11]. The funct field instr[5:0] selects the operation: 100000 add, 100010 sub (rs − rt), 100100 and, 100101 or, 100111 nor. The sources are rs, instr[25:21], and rt, instr[20:16].
- R4: slt (funct 101010) writes 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: lw (opcode 100011) and sw (opcode 101011) use the byte address rs + sign-extended instr[15:0]. lw writes the addressed word to rt. sw writes rt to that word.
- R6: beq (opcode 000100) sets the next PC to PC + 4 + (sign-extended instr[15:0] << 2) when rs equals rt, and to PC + 4 otherwise. It writes no register.
- R7: j (opcode 000010) sets the next PC to {(PC+4)[31:28], instr[25:0], 00} and writes no register.
- R8: jal (opcode 000011) jumps like j and, in the same cycle, writes PC + 4 into register 31.
- R9: Register 0 always reads as zero. A write directed at it is reported on the ports but leaves its value at zero.
- R10: A store cycle reports no register write, and a data-store write is reported only for sw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Active-high synchronous reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write takes effect at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value written to the register |
| dm_we_o | output | 1 | Data-store write takes effect at the next edge |
| dm_addr_o | output | 32 | Byte address of the data-store write |
| dm_wdata_o | output | 32 | Word written to the data store |

## Verification
The bench runs a single straight-line program. Its only source of a non-zero value is the jal link, so every later result depends on the earlier ones having been right. Operands are picked so that the and, or and nor results all differ from one another and from add. The slt pair is run once with a negative operand on each side, which separates a signed compare from an unsigned one. One store uses a negative offset, which catches a missing sign extension. The branches appear as one not-taken and one taken case. Instructions placed between a control transfer and its target would show up as extra register writes, so their absence confirms the target was computed correctly. A write aimed at register 0, followed by a read of register 0, shows that the write was discarded.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LW    = 6'b100011;
    localparam logic [5:0] OPC_SW    = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_J     = 6'b000010;
    localparam logic [5:0] OPC_JAL   = 6'b000011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_NOR = 6'b100111;

    localparam logic [RIDX-1:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_fn_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    typedef enum logic [1:0] {
        DST_RT   = 2'd0,
        DST_RD   = 2'd1,
        DST_LINK = 2'd2
    } dst_sel_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2
    } wb_sel_e;

    typedef struct packed {
        dst_sel_e dst_sel;
        wb_sel_e  wb_sel;
        logic     branch;
        logic     jump;
        logic     mem_rd;
        logic     mem_wr;
        logic     imm_b;
        logic     reg_wr;
        alu_cls_e alu_cls;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] op,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{dst_sel: DST_RT, wb_sel: WB_ALU, branch: 1'b0, jump: 1'b0,
                 mem_rd: 1'b0, mem_wr: 1'b0, imm_b: 1'b0, reg_wr: 1'b0,
                 alu_cls: CLS_ADD};
        unique case (op)
            OPC_RTYPE: begin
                ctrl.dst_sel = DST_RD;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_cls = CLS_FUNCT;
            end
            OPC_LW: begin
                ctrl.wb_sel = WB_MEM;
                ctrl.mem_rd = 1'b1;
                ctrl.imm_b  = 1'b1;
                ctrl.reg_wr = 1'b1;
            end
            OPC_SW: begin
                ctrl.mem_wr = 1'b1;
                ctrl.imm_b  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch  = 1'b1;
                ctrl.alu_cls = CLS_SUB;
            end
            OPC_J: begin
                ctrl.jump = 1'b1;
            end
            OPC_JAL: begin
                ctrl.jump    = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.dst_sel = DST_LINK;
                ctrl.wb_sel  = WB_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_fn_e    fn
);
    always_comb begin
        fn = ALU_ADD;
        unique case (cls)
            CLS_ADD: fn = ALU_ADD;
            CLS_SUB: fn = ALU_SUB;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    FN_NOR:  fn = ALU_NOR;
                    default: fn = ALU_ADD;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) regs_q[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        dm_we_o,
    output logic [31:0] dm_addr_o,
    output logic [31:0] dm_wdata_o
);
    localparam int IA_W = $clog2(IMEM_WORDS);
    localparam int DA_W = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
    end

    core_state_t st_d, st_q;

    logic [XLEN-1:0] instr;
    logic [5:0]      op, funct;
    logic [RIDX-1:0] rs, rt, rd;
    logic [15:0]     imm;
    logic [XLEN-1:0] imm_sx;
    ctrl_t           ctrl;
    alu_fn_e         alu_fn;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] pc_plus4, br_target, j_target, ld_word;
    logic            take_br;
    logic [RIDX-1:0] wr_reg;
    logic [XLEN-1:0] wr_val;
    logic            rf_we, dm_we;

    // fetch and field split
    assign instr  = imem_q[st_q.pc[IA_W+1:2]];
    assign op     = instr[31:26];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign imm    = instr[15:0];
    assign funct  = instr[5:0];
    assign imm_sx = {{(XLEN-16){imm[15]}}, imm};

    sc_main_dec u_main_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .cls   (ctrl.alu_cls),
        .funct (funct),
        .fn    (alu_fn)
    );

    sc_regfile #(.W(XLEN), .NREGS(32)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (wr_reg),
        .wdata   (wr_val),
        .raddr_a (rs),
        .raddr_b (rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign alu_b = ctrl.imm_b ? imm_sx : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // next-PC candidates
    assign pc_plus4  = st_q.pc + 32'd4;
    assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br   = ctrl.branch & alu_zero;

    // data store read and write-back selection
    assign ld_word = ctrl.mem_rd ? dmem_q[alu_y[DA_W+1:2]] : '0;

    always_comb begin
        unique case (ctrl.dst_sel)
            DST_RD:   wr_reg = rd;
            DST_LINK: wr_reg = LINK_REG;
            default:  wr_reg = rt;
        endcase
        unique case (ctrl.wb_sel)
            WB_MEM:  wr_val = ld_word;
            WB_LINK: wr_val = pc_plus4;
            default: wr_val = alu_y;
        endcase
    end

    assign rf_we = ctrl.reg_wr & ~rst;
    assign dm_we = ctrl.mem_wr & ~rst;

    always_comb begin
        st_d = st_q;
        if (ctrl.jump)   st_d.pc = j_target;
        else if (take_br) st_d.pc = br_target;
        else             st_d.pc = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (dm_we) dmem_q[alu_y[DA_W+1:2]] <= rt_val;
    end

    assign pc_o       = st_q.pc;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = wr_reg;
    assign rf_wdata_o = wr_val;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic        rf_we_o,
    input logic [4:0]  rf_waddr_o,
    input logic [31:0] rf_wdata_o,
    input logic        dm_we_o
);
    logic [5:0]  opc;
    logic [31:0] pc_nx;
    assign opc   = instr[31:26];
    assign pc_nx = pc_o + 32'd4;

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_o == 32'd0));

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_BEQ && opc != OPC_J && opc != OPC_JAL) |=> (pc_o == $past(pc_nx)));

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_J) |=> (pc_o == {$past(pc_nx[31:28]), $past(instr[25:0]), 2'b00}));

    // R8
    link_write_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JAL) |-> (rf_we_o && rf_waddr_o == 5'd31 && rf_wdata_o == pc_nx));

    // R10
    store_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> (!rf_we_o && opc == OPC_SW));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .instr      (instr),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .dm_we_o    (dm_we_o)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    always #4 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst        (rst),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    typedef struct {
        logic [31:0] pc;
        bit          rfw;
        logic [4:0]  wa;
        logic [31:0] wd;
        bit          dmw;
        logic [31:0] da;
        logic [31:0] dd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] fn);
        return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
        return {op, 5'(s), 5'(t), im};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input int idx);
        return {op, 26'(idx)};
    endfunction

    task automatic put(input int idx, input logic [31:0] w);
        dut.imem_q[idx] = w;
    endtask

    task automatic exp_rf(input logic [31:0] pc, input int wa, input logic [31:0] wd, input string tag);
        exp_t e;
        e = '{pc: pc, rfw: 1'b1, wa: 5'(wa), wd: wd, dmw: 1'b0, da: '0, dd: '0, tag: tag};
        exp_q.push_back(e);
    endtask
    task automatic exp_dm(input logic [31:0] pc, input logic [31:0] da, input logic [31:0] dd, input string tag);
        exp_t e;
        e = '{pc: pc, rfw: 1'b0, wa: '0, wd: '0, dmw: 1'b1, da: da, dd: dd, tag: tag};
        exp_q.push_back(e);
    endtask
    task automatic exp_none(input logic [31:0] pc, input string tag);
        exp_t e;
        e = '{pc: pc, rfw: 1'b0, wa: '0, wd: '0, dmw: 1'b0, da: '0, dd: '0, tag: tag};
        exp_q.push_back(e);
    endtask

    // monitor: one expected item per executed cycle
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && exp_q.size() > 0) begin
                exp_t e;
                bit   ok;
                e  = exp_q.pop_front();
                ok = (pc_o == e.pc) && (rf_we_o == e.rfw) && (dm_we_o == e.dmw);
                if (e.rfw) ok = ok && (rf_waddr_o == e.wa) && (rf_wdata_o == e.wd);
                if (e.dmw) ok = ok && (dm_addr_o == e.da) && (dm_wdata_o == e.dd);
                n_cmp++;
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s: actual pc=%h rfw=%0b r%0d=%h dmw=%0b [%h]=%h expected pc=%h rfw=%0b r%0d=%h dmw=%0b [%h]=%h",
                             e.tag, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, dm_we_o, dm_addr_o, dm_wdata_o,
                             e.pc, e.rfw, e.wa, e.wd, e.dmw, e.da, e.dd);
                end
            end
        end
    end

    // driver
    initial begin
        #1;
        put(0,  enc_j(6'b000011, 1));                 // jal -> word 1
        put(1,  enc_r(31, 31, 2, 6'b100000));         // add r2 = 8
        put(2,  enc_r(2, 31, 3, 6'b100000));          // add r3 = 12
        put(3,  enc_r(0, 2, 4, 6'b100010));           // sub r4 = -8
        put(4,  enc_r(3, 4, 5, 6'b100100));           // and
        put(5,  enc_r(3, 4, 6, 6'b100101));           // or
        put(6,  enc_r(3, 0, 7, 6'b100111));           // nor
        put(7,  enc_r(4, 2, 8, 6'b101010));           // slt -8 < 8
        put(8,  enc_r(2, 4, 9, 6'b101010));           // slt 8 < -8
        put(9,  enc_i(6'b101011, 2, 3, 16'd4));       // sw r3, 4(r2)
        put(10, enc_i(6'b101011, 3, 4, 16'hFFFC));    // sw r4, -4(r3)
        put(11, enc_i(6'b100011, 2, 10, 16'd4));      // lw r10, 4(r2)
        put(12, enc_i(6'b100011, 2, 11, 16'd0));      // lw r11, 0(r2)
        put(13, enc_r(3, 3, 0, 6'b100000));           // add r0 (discarded)
        put(14, enc_r(0, 3, 12, 6'b100000));          // add r12 = r0 + r3
        put(15, enc_i(6'b000100, 2, 3, 16'd5));       // beq not taken
        put(16, enc_i(6'b000100, 10, 3, 16'd2));      // beq taken -> word 19
        put(17, enc_r(3, 3, 13, 6'b100000));          // skipped
        put(18, enc_r(3, 3, 13, 6'b100000));          // skipped
        put(19, enc_j(6'b000010, 22));                // j -> word 22
        put(20, enc_r(3, 3, 14, 6'b100000));          // skipped
        put(21, enc_r(3, 3, 14, 6'b100000));          // skipped
        put(22, enc_r(31, 0, 15, 6'b100000));         // add r15 = r31
        put(23, enc_j(6'b000010, 23));                // self loop

        exp_rf(32'd0,  31, 32'd4,        "R8 jal link");
        exp_rf(32'd4,  2,  32'd8,        "R3 add");
        exp_rf(32'd8,  3,  32'd12,       "R3 add");
        exp_rf(32'd12, 4,  32'hFFFFFFF8, "R3 sub");
        exp_rf(32'd16, 5,  32'h00000008, "R3 and");
        exp_rf(32'd20, 6,  32'hFFFFFFFC, "R3 or");
        exp_rf(32'd24, 7,  32'hFFFFFFF3, "R3 nor");
        exp_rf(32'd28, 8,  32'd1,        "R4 slt true");
        exp_rf(32'd32, 9,  32'd0,        "R4 slt false");
        exp_dm(32'd36, 32'd12, 32'd12,       "R5 R10 sw");
        exp_dm(32'd40, 32'd8,  32'hFFFFFFF8, "R5 sw negative offset");
        exp_rf(32'd44, 10, 32'd12,       "R5 lw");
        exp_rf(32'd48, 11, 32'hFFFFFFF8, "R5 lw");
        exp_rf(32'd52, 0,  32'd24,       "R9 write to r0");
        exp_rf(32'd56, 12, 32'd12,       "R9 r0 reads zero");
        exp_none(32'd60, "R6 beq not taken");
        exp_none(32'd64, "R6 beq taken");
        exp_none(32'd76, "R7 j");
        exp_rf(32'd88, 15, 32'd4,        "R2 add after jump");
        exp_none(32'd92, "R7 self jump");
        exp_none(32'd92, "R7 self jump");
        exp_none(32'd92, "R7 self jump");

        // R1: reset state
        @(negedge clk);
        n_cmp++;
        if (pc_o !== 32'd0 || rf_we_o !== 1'b0 || dm_we_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual pc=%h rfw=%0b dmw=%0b expected pc=0 rfw=0 dmw=0",
                     pc_o, rf_we_o, dm_we_o);
        end
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d items pending expected 0", exp_q.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule